// File: doc/BRIEF.md
# Multi-Port Interrupt Status Aggregator

This block gathers interrupt events from four serial storage ports into one 32-bit status word that software can read but never write. Each port owns one byte of the word. Event inputs arrive as single-cycle pulses, and each one sets a sticky bit in the byte of its port. A per-port PHY ready level is tracked by a small two-state machine, and its transitions are turned into status bits. The word is a summary only. Clearing happens through side effects on other registers. A read of a port's command status register clears that port's drive-interrupt bit. A write-1-to-clear access to that port's error register clears the other seven bits.

A mode input selects how the word is seen. In IDE mode (`ide_mode` = 1) the word shows the stored bits and drives the interrupt output. In direct-access mode (`ide_mode` = 0) the word reads as zero, while the stored bits are kept. Each PHY tracker has two states. `LINK_DOWN` moves to `LINK_UP` on the *come-up* transition when ready is seen high. `LINK_UP` moves back to `LINK_DOWN` on the *drop* transition when ready is seen low. Both states hold when the input does not change.

Top module: `irq_status_agg`

## Requirements
- R1: Port p (p = 0..3) occupies bits 8p+7 down to 8p of `status_word`. Inside each byte: bit 7 drive interrupt, 6 CRC, 5 data integrity, 4 unknown frame, 3 error response, 2 FIFO, 1 PHY came up, 0 PHY changed.
- R2: A `drive_evt` pulse sets bit 7 of its port on the next clock edge. A `status_rd` pulse for that port clears it. An error-register write does not clear bit 7.
- R3: A `crc_evt` pulse sets both bit 6 and bit 5 of its port.
- R4: A `disparity_evt` pulse sets bit 5 only. A `resp_err_evt` pulse sets bit 3 and bit 5.
- R5: A `frame_evt` pulse sets bit 4. A `fifo_evt` pulse sets bit 2.
- R6: Any change of `phy_ready[p]` between consecutive clock edges sets bit 0 of port p. Only a low-to-high change also sets bit 1.
- R7: An `err_wr[p]` pulse clears each bit i (0..6) of port p for which `err_wdata[i]` is 1. Bits whose data bit is 0, and other ports, are unchanged. `status_rd` does not clear bits 6:0.
- R8: A set bit holds until it is cleared by its own clear path.
- R9: If a set and a clear reach the same bit in the same cycle, the bit ends up set.
- R10: With `ide_mode` = 0, `status_word` is zero. The stored bits are kept and reappear when `ide_mode` returns to 1.
- R11: `irq` is 1 exactly when `ide_mode` is 1 and at least one bit of `status_word` is set.
- R12: After reset all bits are zero and `irq` is 0. The PHY trackers start in `LINK_DOWN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ide_mode | input | 1 | 1 = word visible and interrupt enabled; 0 = direct-access mode, word reads zero |
| phy_ready | input | 4 | PHY ready level, one bit per port |
| drive_evt | input | 4 | Drive interrupt pulse per port |
| crc_evt | input | 4 | CRC error pulse from the last data transfer |
| disparity_evt | input | 4 | Host-detected disparity error pulse |
| resp_err_evt | input | 4 | Error response from device to a data frame |
| frame_evt | input | 4 | Unrecognized frame type pulse |
| fifo_evt | input | 4 | FIFO error pulse |
| status_rd | input | 4 | Read of the port's command status register |
| err_wr | input | 4 | Write strobe of the port's error register |
| err_wdata | input | 7 | Write-1-to-clear data for bits 6:0 |
| status_word | output | 32 | Read-only summary word |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is the same-cycle collision of R9, where an event pulse and its clear reach one bit on the same clock edge. The collision must happen on a bit that was already set, or the test shows nothing. The stimulus first sets the bit, then drives the pulse and the matching `status_rd` or `err_wr` in the same cycle. Partial masks check that a write clears only the named bits. Toggling `ide_mode` while bits are held checks that the hidden state survives.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int FIELD_W   = 8;
    localparam int ERR_W     = FIELD_W - 1;

    localparam int B_PHY_CHG = 0;
    localparam int B_PHY_UP  = 1;
    localparam int B_FIFO    = 2;
    localparam int B_RESP    = 3;
    localparam int B_FRAME   = 4;
    localparam int B_INTEG   = 5;
    localparam int B_CRC     = 6;
    localparam int B_DRIVE   = 7;

    typedef enum logic {
        LINK_DOWN = 1'b0,
        LINK_UP   = 1'b1
    } link_state_e;

    typedef struct packed {
        logic drive;
        logic crc;
        logic disparity;
        logic resp_err;
        logic frame;
        logic fifo;
    } port_evt_t;

endpackage

// File: rtl/phy_edge_fsm.sv
module phy_edge_fsm
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    output logic chg,
    output logic came_up
);

    link_state_e state_q;
    link_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINK_DOWN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINK_DOWN: if (ready)  state_d = LINK_UP;    // come-up
            LINK_UP:   if (!ready) state_d = LINK_DOWN;  // drop
            default:   state_d = LINK_DOWN;
        endcase
    end

    // outputs
    always_comb begin
        chg     = 1'b0;
        came_up = 1'b0;
        unique case (state_q)
            LINK_DOWN: begin
                if (ready) begin
                    chg     = 1'b1;
                    came_up = 1'b1;
                end
            end
            LINK_UP: begin
                if (!ready) chg = 1'b1;
            end
            default: begin
                chg     = 1'b0;
                came_up = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/port_status_reg.sv
module port_status_reg
    import irq_agg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  port_evt_t          evt,
    input  logic               phy_chg,
    input  logic               phy_up,
    input  logic               rd_clr,
    input  logic               wr_clr,
    input  logic [ERR_W-1:0]   clr_mask,
    output logic [FIELD_W-1:0] bits_q
);

    logic [FIELD_W-1:0] set_vec;
    logic [FIELD_W-1:0] clr_vec;
    logic [FIELD_W-1:0] bits_d;

    always_comb begin
        set_vec            = '0;
        set_vec[B_DRIVE]   = evt.drive;
        set_vec[B_CRC]     = evt.crc;
        set_vec[B_INTEG]   = evt.crc | evt.disparity | evt.resp_err;
        set_vec[B_FRAME]   = evt.frame;
        set_vec[B_RESP]    = evt.resp_err;
        set_vec[B_FIFO]    = evt.fifo;
        set_vec[B_PHY_UP]  = phy_up;
        set_vec[B_PHY_CHG] = phy_chg;
    end

    always_comb begin
        clr_vec          = '0;
        clr_vec[B_DRIVE] = rd_clr;
        if (wr_clr) clr_vec[ERR_W-1:0] = clr_mask;
    end

    // a set in the same cycle overrides the clear
    assign bits_d = (bits_q & ~clr_vec) | set_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

endmodule

// File: rtl/status_view.sv
module status_view #(
    parameter int WORD_W = 32
) (
    input  logic              ide_mode,
    input  logic [WORD_W-1:0] raw_word,
    output logic [WORD_W-1:0] status_word,
    output logic              irq
);

    always_comb begin
        status_word = ide_mode ? raw_word : '0;
        irq         = ide_mode & (|raw_word);
    end

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int WORD_W   = NUM_PORTS * FIELD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ide_mode,
    input  logic [NUM_PORTS-1:0] phy_ready,
    input  logic [NUM_PORTS-1:0] drive_evt,
    input  logic [NUM_PORTS-1:0] crc_evt,
    input  logic [NUM_PORTS-1:0] disparity_evt,
    input  logic [NUM_PORTS-1:0] resp_err_evt,
    input  logic [NUM_PORTS-1:0] frame_evt,
    input  logic [NUM_PORTS-1:0] fifo_evt,
    input  logic [NUM_PORTS-1:0] status_rd,
    input  logic [NUM_PORTS-1:0] err_wr,
    input  logic [ERR_W-1:0]     err_wdata,
    output logic [WORD_W-1:0]    status_word,
    output logic                 irq
);

    logic [WORD_W-1:0] raw_word;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        port_evt_t evt;
        logic      chg;
        logic      came_up;

        assign evt = '{drive:     drive_evt[p],
                       crc:       crc_evt[p],
                       disparity: disparity_evt[p],
                       resp_err:  resp_err_evt[p],
                       frame:     frame_evt[p],
                       fifo:      fifo_evt[p]};

        phy_edge_fsm u_phy (
            .clk     (clk),
            .rst_n   (rst_n),
            .ready   (phy_ready[p]),
            .chg     (chg),
            .came_up (came_up)
        );

        port_status_reg u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (evt),
            .phy_chg  (chg),
            .phy_up   (came_up),
            .rd_clr   (status_rd[p]),
            .wr_clr   (err_wr[p]),
            .clr_mask (err_wdata),
            .bits_q   (raw_word[p*FIELD_W +: FIELD_W])
        );
    end

    status_view #(.WORD_W(WORD_W)) u_view (
        .ide_mode    (ide_mode),
        .raw_word    (raw_word),
        .status_word (status_word),
        .irq         (irq)
    );

endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk #(
    parameter int NUM_PORTS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ide_mode,
    input logic [NUM_PORTS-1:0]   phy_ready,
    input logic [NUM_PORTS-1:0]   drive_evt,
    input logic [NUM_PORTS-1:0]   crc_evt,
    input logic [NUM_PORTS-1:0]   status_rd,
    input logic [NUM_PORTS-1:0]   err_wr,
    input logic [6:0]             err_wdata,
    input logic [NUM_PORTS*8-1:0] raw_word,
    input logic [NUM_PORTS*8-1:0] status_word,
    input logic                   irq
);

    // R10
    hidden_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ide_mode |-> status_word == '0);

    // R11
    irq_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ide_mode);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        // R2
        drive_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            drive_evt[p] |=> raw_word[p*8+7]);

        // R2
        drive_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (status_rd[p] && !drive_evt[p]) |=> !raw_word[p*8+7]);

        // R8
        drive_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_word[p*8+7] && !status_rd[p]) |=> raw_word[p*8+7]);

        // R3
        crc_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            crc_evt[p] |=> (raw_word[p*8+6] && raw_word[p*8+5]));

        // R7
        crc_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (err_wr[p] && err_wdata[6] && !crc_evt[p]) |=> !raw_word[p*8+6]);

        // R6
        up_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(raw_word[p*8+1]) |-> $past(phy_ready[p]));
    end

endmodule

bind irq_status_agg irq_status_agg_chk #(.NUM_PORTS(NUM_PORTS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ide_mode    (ide_mode),
    .phy_ready   (phy_ready),
    .drive_evt   (drive_evt),
    .crc_evt     (crc_evt),
    .status_rd   (status_rd),
    .err_wr      (err_wr),
    .err_wdata   (err_wdata),
    .raw_word    (raw_word),
    .status_word (status_word),
    .irq         (irq)
);

// File: tb/irq_status_agg_tb_top.sv
module irq_status_agg_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ide_mode = 1'b1;
    logic [NP-1:0] phy_ready = '0;
    logic [NP-1:0] drive_evt = '0, crc_evt = '0, disparity_evt = '0;
    logic [NP-1:0] resp_err_evt = '0, frame_evt = '0, fifo_evt = '0;
    logic [NP-1:0] status_rd = '0, err_wr = '0;
    logic [6:0]    err_wdata = '0;
    logic [31:0]   status_word;
    logic          irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_agg #(.NUM_PORTS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .ide_mode(ide_mode), .phy_ready(phy_ready),
        .drive_evt(drive_evt), .crc_evt(crc_evt), .disparity_evt(disparity_evt),
        .resp_err_evt(resp_err_evt), .frame_evt(frame_evt), .fifo_evt(fifo_evt),
        .status_rd(status_rd), .err_wr(err_wr), .err_wdata(err_wdata),
        .status_word(status_word), .irq(irq)
    );

    typedef struct {
        string       req;
        logic [31:0] word;
        logic        irq;
    } exp_t;

    exp_t        sb_q[$];
    exp_t        cur;
    int          n_checks = 0;
    int          n_fails  = 0;
    logic [7:0]  m_byte [NP];
    logic [NP-1:0] m_phy = '0;

    task automatic check(string req, logic [31:0] gw, logic [31:0] ew, logic gi, logic ei);
        n_checks++;
        if (gw !== ew || gi !== ei) begin
            n_fails++;
            $display("FAIL %s: word=%h irq=%b expected word=%h irq=%b", req, gw, gi, ew, ei);
        end
    endtask

    // driver: apply current inputs for one edge and push the expected result
    task automatic tick(string req);
        logic [31:0] w;
        exp_t        e;
        for (int p = 0; p < NP; p++) begin
            logic [7:0] b;
            b = m_byte[p];
            if (status_rd[p]) b[7] = 1'b0;
            if (err_wr[p])    b[6:0] = b[6:0] & ~err_wdata;
            if (drive_evt[p]) b[7] = 1'b1;
            if (crc_evt[p])   begin b[6] = 1'b1; b[5] = 1'b1; end
            if (disparity_evt[p]) b[5] = 1'b1;
            if (resp_err_evt[p])  begin b[3] = 1'b1; b[5] = 1'b1; end
            if (frame_evt[p]) b[4] = 1'b1;
            if (fifo_evt[p])  b[2] = 1'b1;
            if (phy_ready[p] != m_phy[p]) begin
                b[0] = 1'b1;
                if (phy_ready[p]) b[1] = 1'b1;
            end
            m_phy[p]  = phy_ready[p];
            m_byte[p] = b;
        end
        w = {m_byte[3], m_byte[2], m_byte[1], m_byte[0]};
        e.req  = req;
        e.word = ide_mode ? w : 32'h0;
        e.irq  = ide_mode && (w != 0);
        sb_q.push_back(e);
        @(posedge clk);
        @(negedge clk);
        drive_evt = '0; crc_evt = '0; disparity_evt = '0; resp_err_evt = '0;
        frame_evt = '0; fifo_evt = '0; status_rd = '0; err_wr = '0; err_wdata = '0;
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            check(cur.req, status_word, cur.word, irq, cur.irq);
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_fails++;
        $display("FAIL watchdog: word=%h irq=%b expected run to finish", status_word, irq);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) m_byte[p] = '0;
        repeat (3) @(negedge clk);
        check("R12 reset", status_word, 32'h0, irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 after release", status_word, 32'h0, irq, 1'b0);

        drive_evt[0] = 1'b1;                 tick("R2 R1 R11 drive sets bit7 port0");
        crc_evt[1] = 1'b1;                   tick("R3 R1 crc port1");
        disparity_evt[2] = 1'b1;             tick("R4 disparity port2");
        resp_err_evt[3] = 1'b1;              tick("R4 R1 resp err port3");
        frame_evt[0] = 1'b1; fifo_evt[0] = 1'b1; tick("R5 frame fifo port0");
        phy_ready[1] = 1'b1;                 tick("R6 phy rise port1");
        err_wr[1] = 1'b1; err_wdata = 7'h03; tick("R7 clear phy bits port1");
        phy_ready[1] = 1'b0;                 tick("R6 phy fall port1 chg only");
        tick("R8 hold");
        tick("R8 hold again");
        status_rd[0] = 1'b1;                 tick("R2 R7 read clears bit7 only");
        drive_evt[0] = 1'b1;                 tick("R2 re-set bit7 port0");
        err_wr[0] = 1'b1; err_wdata = 7'h7F; tick("R2 R7 err write keeps bit7");
        err_wr[1] = 1'b1; err_wdata = 7'h40; tick("R7 partial mask port1");
        disparity_evt[2] = 1'b1; err_wr[2] = 1'b1; err_wdata = 7'h20; tick("R9 set wins over w1c");
        drive_evt[0] = 1'b1; status_rd[0] = 1'b1; tick("R9 set wins over read clear");
        ide_mode = 1'b0;                     tick("R10 hidden word zero");
        fifo_evt[3] = 1'b1;                  tick("R10 R11 event while hidden");
        ide_mode = 1'b1;                     tick("R10 bits reappear");
        status_rd = 4'hF;                    tick("R2 clear all drive bits");
        err_wr = 4'hF; err_wdata = 7'h7F;    tick("R7 R11 clear all, irq low");
        phy_ready = 4'hF;                    tick("R6 all ports rise");

        @(posedge clk);
        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule